// File: doc/BRIEF.md
# Two-Bank SDRAM Command Checker

This block watches the command pins of a synchronous DRAM with two banks. On every rising clock edge it decodes the chip-select, row strobe, column strobe, write enable and clock-enable pins into one command. It keeps a small state record for each bank: idle, row open, bursting, bursting with automatic precharge, or waiting out the precharge time that follows such a burst. Each command is judged against that record. The first illegal command raises a sticky error flag and stores a reason code.

Every cycle the block also reports the decoded command, the target bank, whether the command covers both banks, the automatic-precharge flag and the last column address. It is meant to sit beside a memory controller in simulation or on silicon as a protocol watchdog. It only observes the bus and never drives it. Burst length, precharge recovery time and the quiet gap after a mode-register write are parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is held, `cmdCode` reads 0 (no-operation), `errFlag` reads 0 and `errCode` reads 0.
- R2: With the clock enabled in both the previous and the current cycle, the pins {csN,rasN,casN,weN} decode as follows: 0000 mode set (code 2), 0001 refresh (3), 0010 precharge (6), 0011 activate (7), 0101 read (8), 0100 write (9), 0110 burst stop (10), 0111 no-operation (0). Any pattern with csN high is deselect (1). The decoded command appears on `cmdCode` one clock after the edge that sampled it.
- R3: `cmdBank` follows `ba` (0 selects bank A, 1 selects bank B). A precharge with `a10` high sets `cmdAllBanks` to 1 and reports bank 0, whatever `ba` holds.
- R4: For read and write, `cmdAutoPre` equals `a10`. `colAddr` takes `addrLo[7:0]` and holds it until the next read or write.
- R5: A mode set while either bank is not idle is an error with code 1. With both banks idle it is legal.
- R6: In the 2 cycles after a legal mode set, any command other than no-operation, deselect or an ignored (suspended) cycle is an error with code 2. A command in the third cycle is legal.
- R7: A refresh with the clock enable high, and a self-refresh entry (refresh pins while the clock enable goes from 1 to 0, code 4), are errors with code 3 unless both banks are idle. While in self-refresh, cycles decode as suspended (11) and are ignored. The first cycle with the clock enable high decodes as self-refresh exit (5).
- R8: A read or write issued while a burst with automatic precharge is still running, to either bank, is an error with code 4. A burst lasts BURST_LEN cycles counted from its command, so a read or write BURST_LEN cycles after that command is legal.
- R9: After a burst with automatic precharge ends, an activate to the same bank is an error with code 7 until T_RP cycles have passed. Activate is legal exactly T_RP cycles after the burst ends.
- R10: A read or write to a bank with no open row is an error with code 5. An activate to a bank whose row is open is an error with code 6.
- R11: Burst stop ends any running burst at the cycle it is issued. After it, the other bank may be read at once. For an automatic-precharge burst, the T_RP wait starts at the stop cycle.
- R12: `errFlag` stays 1 once set and `errCode` keeps the reason of the first error until reset. A command that raises an error does not change any bank state.
- R13: A cycle whose previous clock-enable sample was 0 decodes as suspended (code 11), and its command has no effect on bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable sampled this cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| addrLo | input | COL_W | Low address bits carrying the column |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | 1 | Target bank of the decoded command |
| cmdAllBanks | output | 1 | Precharge covers both banks |
| cmdAutoPre | output | 1 | Read/write with automatic precharge |
| colAddr | output | COL_W | Column of the last read or write |
| errFlag | output | 1 | Sticky protocol error |
| errCode | output | 3 | Reason of the first error |

## Verification
Every result of this block, the decoded command fields as well as the error flag and code, becomes visible one clock after the edge that sampled the command. Bank-state effects such as burst lockout and the precharge wait appear only as the verdict on a later command. So the driver stamps each expected item with the cycle count at which it is due (issue cycle plus one), and the monitor compares only items whose stamp matches, on the falling edge. Timing windows are probed at both sides of each edge: the last locked cycle and the first free one for burst end, precharge recovery and the mode-set gap.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_AREF     = 4'd3,
    CMD_SREF_IN  = 4'd4,
    CMD_SREF_OUT = 4'd5,
    CMD_PRE      = 4'd6,
    CMD_ACT      = 4'd7,
    CMD_RD       = 4'd8,
    CMD_WR       = 4'd9,
    CMD_BST      = 4'd10,
    CMD_SUSP     = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MRS_BUSY  = 3'd1,
    ERR_MRS_QUIET = 3'd2,
    ERR_REF_BUSY  = 3'd3,
    ERR_AP_LOCK   = 3'd4,
    ERR_NO_ROW    = 3'd5,
    ERR_ROW_OPEN  = 3'd6,
    ERR_TRP       = 3'd7
  } err_e;

  typedef enum logic [2:0] {
    BK_IDLE     = 3'd0,
    BK_ACTIVE   = 3'd1,
    BK_BURST    = 3'd2,
    BK_BURST_AP = 3'd3,
    BK_RP_WAIT  = 3'd4
  } bank_e;

  // strobes from control to datapath
  typedef struct packed {
    logic errHit;
    err_e errWhy;
  } strobe_t;

  function automatic cmd_e decodeCmd(input logic inSelfRef, input logic ckePrev,
                                     input logic ckeNow, input logic csN,
                                     input logic rasN, input logic casN,
                                     input logic weN);
    cmd_e c;
    if (inSelfRef)     c = ckeNow ? CMD_SREF_OUT : CMD_SUSP;
    else if (!ckePrev) c = CMD_SUSP;
    else if (csN)      c = CMD_DESEL;
    else begin
      unique case ({rasN, casN, weN})
        3'b000:  c = CMD_MRS;
        3'b001:  c = ckeNow ? CMD_AREF : CMD_SREF_IN;
        3'b010:  c = CMD_PRE;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/mon_datapath.sv
module mon_datapath
  import sdram_mon_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             ba,
  input  logic             a10,
  input  logic [COL_W-1:0] addrLo,
  input  logic             selfRef,
  input  strobe_t          strobe,
  output cmd_e             curCmd,
  output logic             tgtBank,
  output logic             apBit,
  output logic [3:0]       cmdCode,
  output logic             cmdBank,
  output logic             cmdAllBanks,
  output logic             cmdAutoPre,
  output logic [COL_W-1:0] colAddr,
  output logic             errFlag,
  output logic [2:0]       errCode
);

  logic             ckePrevQ;
  cmd_e             cmdQ;
  logic             bankQ, allQ, apQ, errQ;
  logic [COL_W-1:0] colQ;
  err_e             codeQ;
  logic             isRw, isPreAll;

  assign curCmd   = decodeCmd(selfRef, ckePrevQ, cke, csN, rasN, casN, weN);
  assign tgtBank  = ba;
  assign apBit    = a10;
  assign isRw     = (curCmd == CMD_RD) || (curCmd == CMD_WR);
  assign isPreAll = (curCmd == CMD_PRE) && a10;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrevQ <= 1'b1;
      cmdQ     <= CMD_NOP;
      bankQ    <= 1'b0;
      allQ     <= 1'b0;
      apQ      <= 1'b0;
      colQ     <= '0;
      errQ     <= 1'b0;
      codeQ    <= ERR_NONE;
    end else begin
      ckePrevQ <= cke;
      cmdQ     <= curCmd;
      allQ     <= isPreAll;
      bankQ    <= isPreAll ? 1'b0 : ba;
      apQ      <= isRw && a10;
      if (isRw) colQ <= addrLo;
      if (strobe.errHit && !errQ) begin
        errQ  <= 1'b1;
        codeQ <= strobe.errWhy;
      end
    end
  end

  assign cmdCode     = cmdQ;
  assign cmdBank     = bankQ;
  assign cmdAllBanks = allQ;
  assign cmdAutoPre  = apQ;
  assign colAddr     = colQ;
  assign errFlag     = errQ;
  assign errCode     = codeQ;

  // R12: error flag never drops while out of reset
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  // R12: first reason is kept
  a_r12_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> $stable(codeQ));

endmodule

// File: rtl/mon_control.sv
module mon_control
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmd_e    curCmd,
  input  logic    tgtBank,
  input  logic    apBit,
  output logic    selfRef,
  output strobe_t strobe
);

  localparam int BANKS   = 2;
  localparam int CNT_MAX = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GAP_W   = $clog2(MRS_GAP + 1);
  localparam logic [CNT_W-1:0] BL_LOAD = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);

  bank_e            bankSt  [BANKS];
  logic [CNT_W-1:0] bankCnt [BANKS];
  logic [BANKS-1:0] isIdle, rowOpen, busyAp, waitRp, hit;
  logic [GAP_W-1:0] quietCnt;
  logic             selfRefQ;
  err_e             why;
  logic             isRw, quietOk, allIdle, anyBusyAp, applyCmd;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign hit[b]     = (tgtBank == 1'(b));
      assign isIdle[b]  = (bankSt[b] == BK_IDLE) ||
                          ((bankSt[b] == BK_RP_WAIT) && (bankCnt[b] == '0));
      assign rowOpen[b] = (bankSt[b] == BK_ACTIVE) || (bankSt[b] == BK_BURST);
      assign busyAp[b]  = (bankSt[b] == BK_BURST_AP) && (bankCnt[b] != '0);
      assign waitRp[b]  = ((bankSt[b] == BK_BURST_AP) && (bankCnt[b] == '0)) ||
                          ((bankSt[b] == BK_RP_WAIT) && (bankCnt[b] != '0));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          bankSt[b]  <= BK_IDLE;
          bankCnt[b] <= '0;
        end else begin
          case (bankSt[b])
            BK_BURST: begin
              if (bankCnt[b] != '0) bankCnt[b] <= bankCnt[b] - 1'b1;
              else                  bankSt[b]  <= BK_ACTIVE;
            end
            BK_BURST_AP: begin
              if (bankCnt[b] != '0) bankCnt[b] <= bankCnt[b] - 1'b1;
              else begin
                bankSt[b]  <= BK_RP_WAIT;
                bankCnt[b] <= RP_LOAD;
              end
            end
            BK_RP_WAIT: begin
              if (bankCnt[b] != '0) bankCnt[b] <= bankCnt[b] - 1'b1;
              else                  bankSt[b]  <= BK_IDLE;
            end
            default: ;
          endcase
          if (applyCmd) begin
            case (curCmd)
              CMD_PRE: if ((apBit || hit[b]) && rowOpen[b]) bankSt[b] <= BK_IDLE;
              CMD_ACT: if (hit[b]) bankSt[b] <= BK_ACTIVE;
              CMD_RD, CMD_WR: begin
                if (hit[b]) begin
                  bankSt[b]  <= apBit ? BK_BURST_AP : BK_BURST;
                  bankCnt[b] <= BL_LOAD;
                end else if (bankSt[b] == BK_BURST) begin
                  bankSt[b] <= BK_ACTIVE;
                end
              end
              CMD_BST: begin
                if (bankSt[b] == BK_BURST) bankSt[b] <= BK_ACTIVE;
                else if (busyAp[b]) begin
                  bankSt[b]  <= BK_RP_WAIT;
                  bankCnt[b] <= RP_LOAD;
                end
              end
              default: ;
            endcase
          end
        end
      end

      // R9: the recovery count never exceeds its window
      a_r9_rp_bound: assert property (@(posedge clk) disable iff (!rstN)
        (bankSt[b] == BK_RP_WAIT) |-> (int'(bankCnt[b]) < T_RP));
    end
  endgenerate

  assign isRw      = (curCmd == CMD_RD) || (curCmd == CMD_WR);
  assign quietOk   = curCmd inside {CMD_NOP, CMD_DESEL, CMD_SUSP};
  assign allIdle   = &isIdle;
  assign anyBusyAp = |busyAp;

  always_comb begin
    why = ERR_NONE;
    if ((quietCnt != '0) && !quietOk) why = ERR_MRS_QUIET;
    else begin
      case (curCmd)
        CMD_MRS:              if (!allIdle) why = ERR_MRS_BUSY;
        CMD_AREF, CMD_SREF_IN: if (!allIdle) why = ERR_REF_BUSY;
        CMD_ACT: begin
          if (|(waitRp & hit))       why = ERR_TRP;
          else if (!(|(isIdle & hit))) why = ERR_ROW_OPEN;
        end
        CMD_RD, CMD_WR: begin
          if (anyBusyAp)              why = ERR_AP_LOCK;
          else if (!(|(rowOpen & hit))) why = ERR_NO_ROW;
        end
        default: ;
      endcase
    end
  end

  assign applyCmd      = (why == ERR_NONE);
  assign strobe.errHit = !applyCmd;
  assign strobe.errWhy = why;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quietCnt <= '0;
      selfRefQ <= 1'b0;
    end else begin
      if (quietCnt != '0) quietCnt <= quietCnt - 1'b1;
      if (applyCmd && (curCmd == CMD_MRS)) quietCnt <= GAP_W'(MRS_GAP);
      if (applyCmd && (curCmd == CMD_SREF_IN)) selfRefQ <= 1'b1;
      if (curCmd == CMD_SREF_OUT) selfRefQ <= 1'b0;
    end
  end

  assign selfRef = selfRefQ;

  // R8: the lockout keeps at most one auto-precharge burst alive
  a_r8_single_ap: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busyAp) <= 1);

  // R6: during the mode-set gap both banks stay idle
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt != '0) |-> allIdle);

  // R7: self-refresh only ever holds with both banks idle
  a_r7_selfref_idle: assert property (@(posedge clk) disable iff (!rstN)
    selfRefQ |-> allIdle);

  // R11: a burst stop never leaves an auto-precharge burst running
  a_r11_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (curCmd == CMD_BST) |=> (busyAp == '0));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             ba,
  input  logic             a10,
  input  logic [COL_W-1:0] addrLo,
  output logic [3:0]       cmdCode,
  output logic             cmdBank,
  output logic             cmdAllBanks,
  output logic             cmdAutoPre,
  output logic [COL_W-1:0] colAddr,
  output logic             errFlag,
  output logic [2:0]       errCode
);

  cmd_e    curCmd;
  logic    tgtBank, apBit, selfRef;
  strobe_t strobe;

  mon_datapath #(.COL_W(COL_W)) dp_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .addrLo(addrLo), .selfRef(selfRef),
    .strobe(strobe), .curCmd(curCmd), .tgtBank(tgtBank), .apBit(apBit),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAllBanks(cmdAllBanks),
    .cmdAutoPre(cmdAutoPre), .colAddr(colAddr), .errFlag(errFlag),
    .errCode(errCode)
  );

  mon_control #(.BURST_LEN(BURST_LEN), .T_RP(T_RP), .MRS_GAP(MRS_GAP)) ctl_i (
    .clk(clk), .rstN(rstN), .curCmd(curCmd), .tgtBank(tgtBank), .apBit(apBit),
    .selfRef(selfRef), .strobe(strobe)
  );

endmodule

// File: tb/sdram_cmd_monitor_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
  import sdram_mon_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1, csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic       ba = 1'b0, a10 = 1'b0;
  logic [7:0] addrLo = '0;
  logic [3:0] cmdCode;
  logic       cmdBank, cmdAllBanks, cmdAutoPre, errFlag;
  logic [7:0] colAddr;
  logic [2:0] errCode;

  always #2 clk = ~clk;

  sdram_cmd_monitor dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .addrLo(addrLo), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAllBanks(cmdAllBanks), .cmdAutoPre(cmdAutoPre),
    .colAddr(colAddr), .errFlag(errFlag), .errCode(errCode)
  );

  typedef struct {
    int         due;
    int         req;
    logic [3:0] cmd;
    logic       bank, all, ap, errF;
    logic [7:0] col;
    logic [2:0] errC;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, nChecks = 0, nFail = 0;
  logic mErr = 1'b0;
  logic [2:0] mCode = '0;
  logic [7:0] mCol = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item in the cycle it is due
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      nChecks++;
      if (cmdCode !== e.cmd || cmdBank !== e.bank || cmdAllBanks !== e.all ||
          cmdAutoPre !== e.ap || colAddr !== e.col || errFlag !== e.errF ||
          errCode !== e.errC) begin
        nFail++;
        $display("FAIL R%0d cyc %0d: got cmd=%0d bank=%0b all=%0b ap=%0b col=%h err=%0b/%0d, expected cmd=%0d bank=%0b all=%0b ap=%0b col=%h err=%0b/%0d",
                 e.req, cyc, cmdCode, cmdBank, cmdAllBanks, cmdAutoPre, colAddr,
                 errFlag, errCode, e.cmd, e.bank, e.all, e.ap, e.col, e.errF, e.errC);
      end
    end
  end

  task automatic drive(input cmd_e pins, input logic ckeV, input cmd_e expCmd,
                       input logic baV, input logic a10V, input logic [7:0] adr,
                       input err_e why, input int req);
    exp_t e;
    @(negedge clk);
    cke = ckeV; ba = baV; a10 = a10V; addrLo = adr;
    case (pins)
      CMD_MRS:              {csN, rasN, casN, weN} = 4'b0000;
      CMD_AREF, CMD_SREF_IN: {csN, rasN, casN, weN} = 4'b0001;
      CMD_PRE:              {csN, rasN, casN, weN} = 4'b0010;
      CMD_ACT:              {csN, rasN, casN, weN} = 4'b0011;
      CMD_RD:               {csN, rasN, casN, weN} = 4'b0101;
      CMD_WR:               {csN, rasN, casN, weN} = 4'b0100;
      CMD_BST:              {csN, rasN, casN, weN} = 4'b0110;
      CMD_DESEL:            {csN, rasN, casN, weN} = 4'b1111;
      default:              {csN, rasN, casN, weN} = 4'b0111;
    endcase
    if (!mErr && why != ERR_NONE) begin mErr = 1'b1; mCode = why; end
    if (expCmd == CMD_RD || expCmd == CMD_WR) mCol = adr;
    e.due  = cyc + 1;
    e.req  = req;
    e.cmd  = expCmd;
    e.all  = (expCmd == CMD_PRE) && a10V;
    e.bank = e.all ? 1'b0 : baV;
    e.ap   = (expCmd == CMD_RD || expCmd == CMD_WR) && a10V;
    e.col  = mCol;
    e.errF = mErr;
    e.errC = mCode;
    q.push_back(e);
  endtask

  task automatic op(input cmd_e k, input logic baV, input logic a10V,
                    input logic [7:0] adr, input err_e why, input int req);
    drive(k, 1'b1, k, baV, a10V, adr, why, req);
  endtask

  task automatic nop(input int n, input int req);
    for (int i = 0; i < n; i++) op(CMD_NOP, 1'b0, 1'b0, 8'h00, ERR_NONE, req);
  endtask

  // R1: reset state checked while reset is held
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cke = 1'b1; {csN, rasN, casN, weN} = 4'b0111;
    ba = 1'b0; a10 = 1'b0; addrLo = '0;
    @(negedge clk);
    nChecks++;
    if (cmdCode !== 4'd0 || errFlag !== 1'b0 || errCode !== 3'd0) begin
      nFail++;
      $display("FAIL R1 reset: got cmd=%0d err=%0b/%0d, expected cmd=0 err=0/0",
               cmdCode, errFlag, errCode);
    end
    mErr = 1'b0; mCode = '0; mCol = '0;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: ran %0d cycles, expected finish earlier", cyc);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R2 R3 R4 R5: legal traffic, decode and field reporting
    doReset();
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 2);
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 3);
    op(CMD_RD,  0, 0, 8'hA5, ERR_NONE, 4);
    op(CMD_WR,  1, 0, 8'h5A, ERR_NONE, 4);
    op(CMD_BST, 0, 0, 8'h00, ERR_NONE, 2);
    nop(1, 2);
    op(CMD_DESEL, 0, 0, 8'h00, ERR_NONE, 2);
    op(CMD_PRE, 1, 0, 8'h00, ERR_NONE, 3);
    op(CMD_PRE, 1, 1, 8'h00, ERR_NONE, 3);
    op(CMD_MRS, 0, 0, 8'h00, ERR_NONE, 5);
    nop(2, 6);
    op(CMD_AREF, 0, 0, 8'h00, ERR_NONE, 2);

    // R6 R12: command inside the gap, later error does not replace code
    doReset();
    op(CMD_MRS, 0, 0, 8'h00, ERR_NONE, 6);
    nop(1, 6);
    op(CMD_ACT, 0, 0, 8'h00, ERR_MRS_QUIET, 6);
    op(CMD_RD, 1, 0, 8'h11, ERR_NO_ROW, 12);

    // R6 boundary, R5 mode set with a row open
    doReset();
    op(CMD_MRS, 0, 0, 8'h00, ERR_NONE, 6);
    nop(1, 6);
    op(CMD_DESEL, 0, 0, 8'h00, ERR_NONE, 6);
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 6);
    op(CMD_MRS, 0, 0, 8'h00, ERR_MRS_BUSY, 5);

    // R6: second gap cycle also locked
    doReset();
    op(CMD_MRS, 0, 0, 8'h00, ERR_NONE, 6);
    nop(1, 6);
    op(CMD_BST, 0, 0, 8'h00, ERR_MRS_QUIET, 6);

    // R7: refresh with a row open
    doReset();
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 7);
    op(CMD_AREF, 0, 0, 8'h00, ERR_REF_BUSY, 7);

    // R7: self-refresh entry, ignored cycle, exit, entry while busy
    doReset();
    drive(CMD_SREF_IN, 1'b0, CMD_SREF_IN, 0, 0, 8'h00, ERR_NONE, 7);
    drive(CMD_ACT, 1'b0, CMD_SUSP, 0, 0, 8'h00, ERR_NONE, 7);
    drive(CMD_NOP, 1'b1, CMD_SREF_OUT, 0, 0, 8'h00, ERR_NONE, 7);
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 7);
    op(CMD_RD, 0, 0, 8'h42, ERR_NONE, 7);
    drive(CMD_SREF_IN, 1'b0, CMD_SREF_IN, 0, 0, 8'h00, ERR_REF_BUSY, 7);

    // R13: command after clock enable low is ignored
    doReset();
    drive(CMD_NOP, 1'b0, CMD_NOP, 0, 0, 8'h00, ERR_NONE, 13);
    drive(CMD_ACT, 1'b1, CMD_SUSP, 0, 0, 8'h00, ERR_NONE, 13);
    op(CMD_RD, 0, 0, 8'h07, ERR_NO_ROW, 13);

    // R8: last locked cycle of an auto-precharge burst
    doReset();
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 8);
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 8);
    op(CMD_RD,  0, 1, 8'h33, ERR_NONE, 8);
    nop(2, 8);
    op(CMD_RD,  1, 0, 8'h44, ERR_AP_LOCK, 8);

    // R8 release and R9 first legal activate
    doReset();
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 8);
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 8);
    op(CMD_RD,  0, 1, 8'h33, ERR_NONE, 8);
    nop(3, 8);
    op(CMD_WR,  1, 0, 8'h66, ERR_NONE, 8);
    nop(2, 9);
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 9);
    op(CMD_RD,  0, 0, 8'h77, ERR_NONE, 9);

    // R9: activate one cycle before recovery ends
    doReset();
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 9);
    op(CMD_WR,  0, 1, 8'h12, ERR_NONE, 9);
    nop(5, 9);
    op(CMD_ACT, 0, 0, 8'h00, ERR_TRP, 9);

    // R10: read with no row, activate on an open row
    doReset();
    op(CMD_RD, 0, 0, 8'h01, ERR_NO_ROW, 10);
    doReset();
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 10);
    op(CMD_ACT, 1, 0, 8'h00, ERR_ROW_OPEN, 10);

    // R11: burst stop ends an auto-precharge burst
    doReset();
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 11);
    op(CMD_ACT, 1, 0, 8'h00, ERR_NONE, 11);
    op(CMD_RD,  0, 1, 8'h21, ERR_NONE, 11);
    op(CMD_BST, 0, 0, 8'h00, ERR_NONE, 11);
    op(CMD_RD,  1, 0, 8'h22, ERR_NONE, 11);
    nop(1, 11);
    op(CMD_ACT, 0, 0, 8'h00, ERR_NONE, 11);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule